// File: doc/BRIEF.md
# Three-wire serial EEPROM target

This block models the target side of a three-wire serial EEPROM with 256 words of 16 bits, stored in registers. A fast system clock samples chip select, serial clock and serial data-in. After a double-flop synchroniser on each input, the block detects the rising edges of the serial clock. A command opens with a start bit. A two-bit opcode and an eight-bit address follow, and write-type commands add sixteen data bits. Each bit is sent most significant first and is taken on a serial-clock rising edge.

Reads return a leading zero and then the addressed word. If the host keeps clocking with chip select high, the next word follows. Program commands (single-word write and erase, and the whole-array write and erase) run only after an enable command. Each one starts a self-timed cycle on the falling edge of chip select. The cycle length is a count of system clocks. If the host raises chip select again while the cycle runs, data-out carries busy (0) and then ready (1). Data-out has a separate enable, and that enable is low whenever nothing is driven.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, the output enable is low, programming is disabled, and every word reads 16'hFFFF.
- R2: While chip select is high and no command is in progress, serial-clock rising edges with data-in low are ignored. The first rising edge with data-in high is the start bit.
- R3: The opcode follows the start bit and the address follows the opcode. Opcode 2'b10 (READ) drives a 0 on the final address edge, then the 16 data bits MSB first, one bit per rising edge.
- R4: With chip select held high, a READ continues into address+1 with no extra leading zero, and wraps from 8'hFF to 8'h00.
- R5: Opcode 00 with address bits [7:6]=11 enables programming and =00 disables it. WRITE, ERASE, ERAL and WRAL leave the array unchanged while programming is disabled.
- R6: Opcode 2'b01 (WRITE) is followed by 16 data bits, 27 edges in total including the start bit. It stores the data at the address.
- R7: Opcode 2'b11 (ERASE) sets the addressed word to 16'hFFFF.
- R8: Opcode 00 with address bits [7:6]=10 (ERAL) sets every word to 16'hFFFF. With [7:6]=01 (WRAL) it takes 16 data bits and writes them to every word.
- R9: A program cycle starts on the falling edge of chip select after a complete program command. It runs to completion with chip select low. It lasts WORD_CYC system clocks for single-word commands and BULK_CYC for whole-array commands.
- R10: If chip select rises during a program cycle, data-out is enabled and reads 0 while busy and 1 once ready. The enable drops when chip select falls. When no cycle is running, raising chip select enables nothing.
- R11: A start bit sent during a program cycle is not accepted, and the status output keeps showing busy.
- R12: While chip select is low, the output is disabled and the command logic is reset. A command cut short by chip select falling has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| doe_o | output | 1 | Output enable for do_o |

## Verification
Status display and command acceptance can meet in the same system cycle. The status flag is set by a chip-select rise during a program cycle and cleared when the command logic leaves idle. The bench sends a full READ header while the status output shows busy. It expects data-out to stay at 0 with no read data, and it expects the addressed word to be readable unchanged once the cycle ends. Cycle completion and the status window also overlap: a whole-array write is polled after the single-word length has passed, and the bench expects it to still be busy.

// File: rtl/uwire_eeprom_pkg.sv
package uwire_eeprom_pkg;
  typedef enum logic [1:0] {PG_WRITE, PG_ERASE, PG_ERAL, PG_WRAL} prog_op_e;
  typedef enum logic [2:0] {C_IDLE, C_HDR, C_DATA, C_READ, C_DONE} cmd_state_e;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] EXT_EWEN  = 2'b11;
  localparam logic [1:0] EXT_EWDS  = 2'b00;
  localparam logic [1:0] EXT_ERAL  = 2'b10;
endpackage

// File: rtl/uwire_sync.sv
module uwire_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], raw_i[g]};
    end
    assign sync_o[g] = sh_q[1];
    assign prev_o[g] = sh_q[2];
  end
endmodule

// File: rtl/uwire_cmd.sv
module uwire_cmd
  import uwire_eeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sk_rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_bit_o,
  output logic          rd_active_o,
  output logic          idle_o,
  output logic          ewen_o,
  output logic          ewds_o,
  output logic          pend_o,
  output prog_op_e      pend_op_o,
  output logic [AW-1:0] pend_addr_o,
  output logic [DW-1:0] pend_data_o
);
  localparam int HDR_W = 2 + AW;
  localparam int MAXB  = (HDR_W > DW) ? HDR_W : DW;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int BIT_W = $clog2(DW);

  cmd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-1:0] hdr_q, hdr_nx;
  logic [DW-1:0]    dat_q, dat_nx;
  logic [BIT_W-1:0] bidx_q;
  logic [1:0]       opc, ext;

  assign hdr_nx = {hdr_q[HDR_W-2:0], di_i};
  assign dat_nx = {dat_q[DW-2:0], di_i};
  assign opc    = hdr_nx[HDR_W-1 -: 2];
  assign ext    = hdr_nx[AW-1 -: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= C_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      dat_q     <= '0;
      bidx_q    <= '0;
      rd_addr_o <= '0;
      rd_bit_o  <= 1'b0;
      ewen_o    <= 1'b0;
      ewds_o    <= 1'b0;
      pend_o    <= 1'b0;
      pend_op_o <= PG_WRITE;
    end else begin
      ewen_o <= 1'b0;
      ewds_o <= 1'b0;
      if (!cs_i) begin
        state_q <= C_IDLE;
        pend_o  <= 1'b0;
        cnt_q   <= '0;
      end else if (sk_rise_i) begin
        unique case (state_q)
          C_IDLE: if (di_i && !busy_i) begin
            state_q <= C_HDR;
            cnt_q   <= '0;
          end
          C_HDR: begin
            hdr_q <= hdr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              if (opc == OPC_READ) begin
                rd_addr_o <= hdr_nx[AW-1:0];
                bidx_q    <= '0;
                rd_bit_o  <= 1'b0;  // leading zero
                state_q   <= C_READ;
              end else if (opc == OPC_WRITE) begin
                pend_op_o <= PG_WRITE;
                cnt_q     <= '0;
                state_q   <= C_DATA;
              end else if (opc == OPC_ERASE) begin
                pend_op_o <= PG_ERASE;
                pend_o    <= 1'b1;
                state_q   <= C_DONE;
              end else if (ext == EXT_EWEN) begin
                ewen_o  <= 1'b1;
                state_q <= C_DONE;
              end else if (ext == EXT_EWDS) begin
                ewds_o  <= 1'b1;
                state_q <= C_DONE;
              end else if (ext == EXT_ERAL) begin
                pend_op_o <= PG_ERAL;
                pend_o    <= 1'b1;
                state_q   <= C_DONE;
              end else begin
                pend_op_o <= PG_WRAL;
                cnt_q     <= '0;
                state_q   <= C_DATA;
              end
            end
          end
          C_DATA: begin
            dat_q <= dat_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DW - 1)) begin
              pend_o  <= 1'b1;
              state_q <= C_DONE;
            end
          end
          C_READ: begin
            rd_bit_o <= rd_word_i[BIT_W'(DW - 1) - bidx_q];
            if (bidx_q == BIT_W'(DW - 1)) begin
              bidx_q    <= '0;
              rd_addr_o <= rd_addr_o + 1'b1;
            end else begin
              bidx_q <= bidx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active_o = (state_q == C_READ);
  assign idle_o      = (state_q == C_IDLE);
  assign pend_addr_o = hdr_q[AW-1:0];
  assign pend_data_o = dat_q;
endmodule

// File: rtl/uwire_core.sv
module uwire_core
  import uwire_eeprom_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WORD_CYC = 400,
  parameter int BULK_CYC = 800
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_rise_i,
  input  logic          cs_fall_i,
  input  logic          cmd_idle_i,
  input  logic          ewen_i,
  input  logic          ewds_i,
  input  logic          pend_i,
  input  prog_op_e      pend_op_i,
  input  logic [AW-1:0] pend_addr_i,
  input  logic [DW-1:0] pend_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_word_o,
  output logic          busy_o,
  output logic          wen_o,
  output logic          stat_en_o
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = (BULK_CYC > WORD_CYC) ? BULK_CYC : WORD_CYC;
  localparam int CYC_W = $clog2(MAXC + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [CYC_W-1:0] cyc_q;
  prog_op_e         op_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic             start, commit, bulk_nx, bulk_q, fill_ones;

  assign start     = cs_fall_i && pend_i && wen_o && !busy_o;
  assign commit    = busy_o && (cyc_q == '0);
  assign bulk_nx   = (pend_op_i == PG_ERAL) || (pend_op_i == PG_WRAL);
  assign bulk_q    = (op_q == PG_ERAL) || (op_q == PG_WRAL);
  assign fill_ones = (op_q == PG_ERASE) || (op_q == PG_ERAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wen_o <= 1'b0;
    else if (ewen_i) wen_o <= 1'b1;
    else if (ewds_i) wen_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cyc_q  <= '0;
      op_q   <= PG_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      cyc_q  <= bulk_nx ? CYC_W'(BULK_CYC - 1) : CYC_W'(WORD_CYC - 1);
      op_q   <= pend_op_i;
      addr_q <= pend_addr_i;
      data_q <= pend_data_i;
    end else if (commit) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cyc_q <= cyc_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++)
        if (bulk_q || addr_q == AW'(i)) mem[i] <= fill_ones ? '1 : data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stat_en_o <= 1'b0;
    else if (cs_fall_i)           stat_en_o <= 1'b0;
    else if (cs_rise_i && busy_o) stat_en_o <= 1'b1;
    else if (!cmd_idle_i)         stat_en_o <= 1'b0;
  end

  assign rd_word_o = mem[rd_addr_i];
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_eeprom_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WORD_CYC = 400,
  parameter int BULK_CYC = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic doe_o
);
  logic [2:0]    s_now, s_prev;
  logic          cs_s, sk_rise, di_s, cs_rise, cs_fall;
  logic [AW-1:0] rd_addr, pend_addr;
  logic [DW-1:0] rd_word, pend_data;
  logic          rd_bit, rd_active, cmd_idle, ewen, ewds, pend;
  logic          busy, wen, stat_en;
  prog_op_e      pend_op;

  uwire_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({di_i, sk_i, cs_i}),
    .sync_o(s_now),
    .prev_o(s_prev)
  );

  assign cs_s    = s_now[0];
  assign di_s    = s_now[2];
  assign sk_rise = s_now[1] & ~s_prev[1];
  assign cs_rise = s_now[0] & ~s_prev[0];
  assign cs_fall = ~s_now[0] & s_prev[0];

  uwire_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_s),
    .sk_rise_i  (sk_rise),
    .di_i       (di_s),
    .busy_i     (busy),
    .rd_word_i  (rd_word),
    .rd_addr_o  (rd_addr),
    .rd_bit_o   (rd_bit),
    .rd_active_o(rd_active),
    .idle_o     (cmd_idle),
    .ewen_o     (ewen),
    .ewds_o     (ewds),
    .pend_o     (pend),
    .pend_op_o  (pend_op),
    .pend_addr_o(pend_addr),
    .pend_data_o(pend_data)
  );

  uwire_core #(.AW(AW), .DW(DW), .WORD_CYC(WORD_CYC), .BULK_CYC(BULK_CYC)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_rise_i  (cs_rise),
    .cs_fall_i  (cs_fall),
    .cmd_idle_i (cmd_idle),
    .ewen_i     (ewen),
    .ewds_i     (ewds),
    .pend_i     (pend),
    .pend_op_i  (pend_op),
    .pend_addr_i(pend_addr),
    .pend_data_i(pend_data),
    .rd_addr_i  (rd_addr),
    .rd_word_o  (rd_word),
    .busy_o     (busy),
    .wen_o      (wen),
    .stat_en_o  (stat_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      do_o  <= 1'b0;
      doe_o <= 1'b0;
    end else begin
      doe_o <= rd_active | stat_en;
      do_o  <= stat_en ? ~busy : rd_bit;
    end
  end
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_sync,
  input logic cs_fall,
  input logic busy,
  input logic wen,
  input logic stat_en,
  input logic cmd_idle,
  input logic doe,
  input logic dout
);
  // R12
  cs_low_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_sync && $past(!cs_sync)) |=> !doe);

  // R9
  prog_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cs_fall));

  // R5
  prog_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wen));

  // R11
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_idle) |=> cmd_idle);

  // R10
  status_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_en) && $past(busy)) |-> (doe && !dout));
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_sync (cs_s),
  .cs_fall (cs_fall),
  .busy    (busy),
  .wen     (wen),
  .stat_en (stat_en),
  .cmd_idle(cmd_idle),
  .doe     (doe_o),
  .dout    (do_o)
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
  localparam int WORD_CYC = 300;
  localparam int BULK_CYC = 600;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0;
  logic do_o, doe_o;

  int n_chk = 0, n_fail = 0;
  int low_cnt = 0;
  bit wen_m = 1'b0;
  logic [15:0] m [256];

  always #4 clk = ~clk;

  uwire_eeprom #(.WORD_CYC(WORD_CYC), .BULK_CYC(BULK_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .do_o(do_o), .doe_o(doe_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock reference: with chip select low, output stays disabled (R12)
  always @(posedge clk) low_cnt <= cs_i ? 0 : low_cnt + 1;
  always @(negedge clk)
    if (rst_ni && low_cnt > 5) chk(doe_o === 1'b0, "R12 oe while deselected", {15'd0, doe_o}, 16'd0);

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di_i = b; wclk(6); sk_i = 1'b1; wclk(6); sk_i = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask

  task automatic cs_hi();
    cs_i = 1'b1; wclk(6);
  endtask

  task automatic cs_lo();
    cs_i = 1'b0; di_i = 1'b0; wclk(6);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a);
    sk_bit(1'b1); send({14'd0, op}, 2); send({8'd0, a}, 8);
  endtask

  task automatic rd(input logic [7:0] a, input int n, input string tag);
    cs_hi(); hdr(2'b10, a);
    chk(doe_o === 1'b1 && do_o === 1'b0, {tag, " leading zero"}, {14'd0, doe_o, do_o}, 16'h0002);
    for (int w = 0; w < n; w++) begin
      logic [15:0] got;
      logic [7:0] wa;
      got = '0;
      wa = a + 8'(w);
      for (int b = 0; b < 16; b++) begin
        sk_bit(1'b0);
        got = {got[14:0], do_o};
      end
      chk(got === m[wa], tag, got, m[wa]);
    end
    cs_lo();
  endtask

  task automatic ext(input logic [1:0] sel);
    cs_hi(); hdr(2'b00, {sel, 6'd0}); cs_lo();
    if (sel == 2'b11) wen_m = 1'b1;
    if (sel == 2'b00) wen_m = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cs_hi(); hdr(2'b01, a); send(d, 16); cs_lo();
    if (wen_m) m[a] = d;
  endtask

  task automatic poll(input logic exp_busy, input string tag);
    cs_hi(); wclk(2);
    chk(doe_o === 1'b1 && do_o === !exp_busy, tag, {14'd0, doe_o, do_o}, {14'd0, 1'b1, !exp_busy});
    cs_lo();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 16'hFFFF;
    wclk(3); rst_ni = 1'b1; wclk(3);
    chk(doe_o === 1'b0, "R1 oe after reset", {15'd0, doe_o}, 16'd0);

    // R2: idle clocks with data-in low before the start bit
    cs_hi(); sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b0);
    chk(doe_o === 1'b0, "R2 idle clocks", {15'd0, doe_o}, 16'd0);
    cs_lo();
    rd(8'h05, 1, "R1 R3 reset content");

    // R5: write while disabled is ignored and starts no cycle
    wr(8'h12, 16'hA5C3);
    cs_hi(); wclk(4);
    chk(doe_o === 1'b0, "R10 no status without cycle", {15'd0, doe_o}, 16'd0);
    cs_lo();
    rd(8'h12, 1, "R5 write while disabled");

    // R6 R9 R10 R11
    ext(2'b11);
    cs_hi(); hdr(2'b01, 8'h12); send(16'hA5C3, 16); cs_lo();
    m[8'h12] = 16'hA5C3;
    wclk(4); cs_hi(); wclk(2);
    chk(doe_o === 1'b1 && do_o === 1'b0, "R10 busy status", {14'd0, doe_o, do_o}, 16'h0002);
    hdr(2'b10, 8'h12);
    chk(doe_o === 1'b1 && do_o === 1'b0, "R11 start during busy", {14'd0, doe_o, do_o}, 16'h0002);
    wclk(WORD_CYC);
    chk(doe_o === 1'b1 && do_o === 1'b1, "R10 ready status", {14'd0, doe_o, do_o}, 16'h0003);
    cs_lo();
    chk(doe_o === 1'b0, "R10 oe off at cs fall", {15'd0, doe_o}, 16'd0);
    rd(8'h12, 1, "R6 write data");

    // R4 sequential and wrap
    wr(8'h13, 16'h1234); wclk(WORD_CYC + 10);
    rd(8'h12, 2, "R4 sequential");
    wr(8'hFF, 16'hBEEF); wclk(WORD_CYC + 10);
    rd(8'hFF, 2, "R4 wrap");

    // R7
    cs_hi(); hdr(2'b11, 8'h12); cs_lo(); m[8'h12] = 16'hFFFF;
    wclk(WORD_CYC + 10);
    rd(8'h12, 2, "R7 erase");

    // R12: truncated write
    cs_hi(); hdr(2'b01, 8'h20); send(16'h0123, 10); cs_lo();
    cs_hi(); wclk(4);
    chk(doe_o === 1'b0, "R12 truncated no cycle", {15'd0, doe_o}, 16'd0);
    cs_lo();
    rd(8'h20, 1, "R12 truncated write");

    // R8 R9: WRAL, still busy after the single-word length
    cs_hi(); hdr(2'b00, 8'h40); send(16'h5A5A, 16); cs_lo();
    for (int i = 0; i < 256; i++) m[i] = 16'h5A5A;
    wclk(WORD_CYC + 20);
    poll(1'b1, "R9 bulk still busy");
    wclk(BULK_CYC);
    rd(8'h00, 1, "R8 wral low");
    rd(8'h80, 1, "R8 wral high");

    // R8: ERAL
    cs_hi(); hdr(2'b00, 8'h80); cs_lo();
    for (int i = 0; i < 256; i++) m[i] = 16'hFFFF;
    wclk(BULK_CYC + 10);
    rd(8'h33, 1, "R8 eral");

    // R5: disable again
    wr(8'h40, 16'h0F0F); wclk(WORD_CYC + 10);
    ext(2'b00);
    wr(8'h40, 16'h0000); wclk(WORD_CYC + 10);
    rd(8'h40, 1, "R5 write after disable");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule